// File: doc/BRIEF.md
# DMA Transfer Cycle Sequencer

This block is the state machine that paces the bus cycles of one DMA channel once that channel has been granted the bus. It leaves its idle state on a granted request and passes through a start state. It then runs one bus transfer after another. Each state lasts exactly one clock. The sequencer drives the read strobe, the write strobe, the channel acknowledge, a one-cycle address-advance pulse and a one-cycle done pulse at the end of a burst.

A burst ends for different reasons depending on the transfer mode. A single-mode burst stops after one transfer. A demand-mode burst stops when the request falls. A block-mode burst runs until terminal count or end-of-process. A memory-to-memory setting replaces the normal transfer with an eight-state sequence: a four-state read half followed by a four-state write half. Two timing options are available. Compressed timing removes states from each transfer. Extended write opens the write strobe one state earlier.

Top module: `dma_xfer_seq`

## Requirements
- R1: While reset is held and after it is released, the sequencer is idle and every output (dack, rd_stb, wr_stb, adv, done) is 0. A request without grant leaves it idle.
- R2: With grant and dreq both 1 in idle, the next cycle is the start state, where all outputs are still 0. If dreq is 0 during the start state, the sequencer returns to idle without raising any strobe. Otherwise dack is 1 from the next cycle until the burst ends.
- R3: A normal transfer takes four cycles. Cycle 1 has dack only. rd_stb is 1 in cycles 2 and 3. wr_stb is 1 in cycle 3 (late write). adv is 1 in cycle 4 only. Every further transfer of the burst again takes four cycles.
- R4: With ext_write=1 and normal timing, wr_stb is also 1 in transfer cycle 2.
- R5: With compressed=1 and mem2mem=0, the first transfer takes three cycles: dack only, then rd_stb and wr_stb together, then adv. Each further transfer takes two cycles: strobes, then adv. ext_write has no effect in this case.
- R6: With mem2mem=1, each transfer takes eight cycles. rd_stb is 1 in cycles 2 and 3. adv is 1 in cycles 4 and 8. wr_stb is 1 in cycle 7, and also in cycle 6 if ext_write=1. compressed has no effect. The burst continues regardless of mode and dreq until tc or end-of-process.
- R7: xfer_mode 2'b00 (demand): the burst stops at the end of the first transfer whose last cycle sees dreq=0, and otherwise starts another transfer.
- R8: xfer_mode 2'b01 (single; 2'b11 behaves the same): exactly one transfer is made per start.
- R9: xfer_mode 2'b10 (block): after the start state, dreq is ignored. The burst stops only on tc or end-of-process.
- R10: eop_n=0 in any active cycle lets the current transfer finish and then ends the burst.
- R11: tc=1 in the last cycle of a transfer ends the burst. done is 1 only in the last cycle of the final transfer, and the next cycle is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| grant | input | 1 | Bus granted to this channel |
| dreq | input | 1 | Channel request, active high |
| xfer_mode | input | 2 | 00 demand, 01 single, 10 block, 11 as single |
| mem2mem | input | 1 | Memory-to-memory transfers |
| compressed | input | 1 | Compressed timing option |
| ext_write | input | 1 | Extended (early) write strobe option |
| tc | input | 1 | Terminal count reached on this transfer |
| eop_n | input | 1 | External end-of-process, active low |
| dack | output | 1 | Channel acknowledge |
| rd_stb | output | 1 | Read strobe |
| wr_stb | output | 1 | Write strobe |
| adv | output | 1 | Address-advance pulse |
| done | output | 1 | Burst finished, one cycle |

## Verification
The bench targets the places where the modes diverge.

- A dreq drop during the start state must produce no strobe at all. A design that latched the request too early would run one transfer anyway.
- In block and memory-to-memory bursts, dreq is pulled low mid-burst. A design that treated them like demand mode would stop one or more transfers early.
- An end-of-process pulse in the first cycle of a transfer must still let that transfer finish. A design that aborted at once would lose the strobes and the adv pulse.
- Compressed timing is set together with memory-to-memory, and extended write together with compressed timing. A design that honoured an ignored option would shorten or reshape the cycle pattern.

// File: rtl/dseq_pkg.sv
package dseq_pkg;

  typedef enum logic [3:0] {
    SQ_IDLE = 4'd0,
    SQ_S0   = 4'd1,
    SQ_S1   = 4'd2,
    SQ_S2   = 4'd3,
    SQ_S3   = 4'd4,
    SQ_S4   = 4'd5,
    SQ_RD1  = 4'd6,
    SQ_RD2  = 4'd7,
    SQ_RD3  = 4'd8,
    SQ_RD4  = 4'd9,
    SQ_WR1  = 4'd10,
    SQ_WR2  = 4'd11,
    SQ_WR3  = 4'd12,
    SQ_WR4  = 4'd13
  } seq_st_e;

  typedef enum logic [1:0] {
    XM_DEMAND = 2'b00,
    XM_SINGLE = 2'b01,
    XM_BLOCK  = 2'b10,
    XM_RSVD   = 2'b11
  } xmode_e;

  typedef struct packed {
    logic dack;
    logic rd;
    logic wr;
    logic adv;
  } strb_t;

endpackage

// File: rtl/dseq_rst_sync.sv
module dseq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q
);
  localparam int TOP = STAGES - 1;

  logic [TOP:0] sh_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= 1'b0;
        else        sh_q <= 1'b1;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[TOP-1:0], 1'b1};
      end
    end
  endgenerate

  assign rst_q = sh_q[TOP];
endmodule

// File: rtl/dseq_eop_track.sv
module dseq_eop_track (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic eop_n,
  output logic eop_hit
);
  logic lat_q;
  logic lat_en;
  logic lat_d;

  // capture while active, clear whenever idle
  always_comb begin
    lat_en = !active || !eop_n;
    lat_d  = active;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lat_q <= 1'b0;
    else if (lat_en) lat_q <= lat_d;
  end

  assign eop_hit = active && (lat_q || !eop_n);
endmodule

// File: rtl/dseq_burst_judge.sv
module dseq_burst_judge
  import dseq_pkg::*;
(
  input  xmode_e mode,
  input  logic   mem2mem,
  input  logic   tc,
  input  logic   eop_hit,
  input  logic   dreq,
  output logic   stop
);
  always_comb begin
    if (mem2mem) begin
      stop = tc || eop_hit;
    end else begin
      case (mode)
        XM_DEMAND: stop = tc || eop_hit || !dreq;
        XM_BLOCK:  stop = tc || eop_hit;
        default:   stop = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/dseq_strobe_dec.sv
module dseq_strobe_dec
  import dseq_pkg::*;
(
  input  seq_st_e st,
  input  logic    comp_eff,
  input  logic    ext_write,
  output strb_t   strb
);
  always_comb begin
    strb = '0;
    case (st)
      SQ_S1:  strb.dack = 1'b1;
      SQ_S2:  begin
        strb.dack = 1'b1;
        strb.rd   = 1'b1;
        strb.wr   = comp_eff || ext_write;
      end
      SQ_S3:  begin
        strb.dack = 1'b1;
        strb.rd   = 1'b1;
        strb.wr   = 1'b1;
      end
      SQ_S4:  begin
        strb.dack = 1'b1;
        strb.adv  = 1'b1;
      end
      SQ_RD1: strb.dack = 1'b1;
      SQ_RD2, SQ_RD3: begin
        strb.dack = 1'b1;
        strb.rd   = 1'b1;
      end
      SQ_RD4: begin
        strb.dack = 1'b1;
        strb.adv  = 1'b1;
      end
      SQ_WR1: strb.dack = 1'b1;
      SQ_WR2: begin
        strb.dack = 1'b1;
        strb.wr   = ext_write;
      end
      SQ_WR3: begin
        strb.dack = 1'b1;
        strb.wr   = 1'b1;
      end
      SQ_WR4: begin
        strb.dack = 1'b1;
        strb.adv  = 1'b1;
      end
      default: strb = '0;
    endcase
  end
endmodule

// File: rtl/dma_xfer_seq.sv
module dma_xfer_seq
  import dseq_pkg::*;
#(
  parameter int RST_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       grant,
  input  logic       dreq,
  input  logic [1:0] xfer_mode,
  input  logic       mem2mem,
  input  logic       compressed,
  input  logic       ext_write,
  input  logic       tc,
  input  logic       eop_n,
  output logic       dack,
  output logic       rd_stb,
  output logic       wr_stb,
  output logic       adv,
  output logic       done
);
  seq_st_e st_q;
  seq_st_e st_d;
  xmode_e  mode;
  strb_t   strb;
  logic    rst_q;
  logic    comp_eff;
  logic    active;
  logic    eop_hit;
  logic    stop;
  logic    last;

  assign mode     = xmode_e'(xfer_mode);
  assign comp_eff = compressed && !mem2mem;
  assign active   = (st_q != SQ_IDLE);
  assign last     = (st_q == SQ_S4) || (st_q == SQ_WR4);

  dseq_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk   (clk),
    .rst_n (rst_n),
    .rst_q (rst_q)
  );

  dseq_eop_track u_eop (
    .clk     (clk),
    .rst_n   (rst_q),
    .active  (active),
    .eop_n   (eop_n),
    .eop_hit (eop_hit)
  );

  dseq_burst_judge u_judge (
    .mode    (mode),
    .mem2mem (mem2mem),
    .tc      (tc),
    .eop_hit (eop_hit),
    .dreq    (dreq),
    .stop    (stop)
  );

  dseq_strobe_dec u_dec (
    .st        (st_q),
    .comp_eff  (comp_eff),
    .ext_write (ext_write),
    .strb      (strb)
  );

  // next-state
  always_comb begin
    st_d = st_q;
    case (st_q)
      SQ_IDLE: if (grant && dreq) st_d = SQ_S0;
      SQ_S0: begin
        if (!dreq)        st_d = SQ_IDLE;
        else if (mem2mem) st_d = SQ_RD1;
        else              st_d = SQ_S1;
      end
      SQ_S1:  st_d = SQ_S2;
      SQ_S2:  st_d = comp_eff ? SQ_S4 : SQ_S3;
      SQ_S3:  st_d = SQ_S4;
      SQ_S4: begin
        if (stop)          st_d = SQ_IDLE;
        else if (comp_eff) st_d = SQ_S2;
        else               st_d = SQ_S1;
      end
      SQ_RD1: st_d = SQ_RD2;
      SQ_RD2: st_d = SQ_RD3;
      SQ_RD3: st_d = SQ_RD4;
      SQ_RD4: st_d = SQ_WR1;
      SQ_WR1: st_d = SQ_WR2;
      SQ_WR2: st_d = SQ_WR3;
      SQ_WR3: st_d = SQ_WR4;
      SQ_WR4: st_d = stop ? SQ_IDLE : SQ_RD1;
      default: st_d = SQ_IDLE;
    endcase
  end

  // state register
  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) st_q <= SQ_IDLE;
    else        st_q <= st_d;
  end

  assign dack   = strb.dack;
  assign rd_stb = strb.rd;
  assign wr_stb = strb.wr;
  assign adv    = strb.adv;
  assign done   = last && stop;

  // R11
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_q)
    done |=> (st_q == SQ_IDLE));

  // R2
  dack_start_chk: assert property (@(posedge clk) disable iff (!rst_q)
    $rose(dack) |-> $past(st_q == SQ_S0));

  // R3
  adv_pulse_chk: assert property (@(posedge clk) disable iff (!rst_q)
    adv |=> !adv);

  // R5
  comp_skip_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (st_q == SQ_S2 && compressed && !mem2mem) |=> (st_q == SQ_S4));

  // R6
  m2m_split_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (st_q == SQ_RD4) |=> (st_q == SQ_WR1));

  // R8
  single_one_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (st_q == SQ_S4 && !mem2mem && mode == XM_SINGLE) |=> (st_q == SQ_IDLE));

  // R9
  block_hold_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (st_q == SQ_S4 && !mem2mem && mode == XM_BLOCK && !tc && !eop_hit)
      |=> (st_q != SQ_IDLE));

  // R10
  eop_end_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (last && eop_hit) |=> (st_q == SQ_IDLE));

endmodule

// File: tb/tb_dma_xfer_seq.sv
`timescale 1ns/1ps
module tb_dma_xfer_seq;
  logic       clk;
  logic       rst_n;
  logic       grant, dreq, mem2mem, compressed, ext_write, tc, eop_n;
  logic [1:0] xfer_mode;
  logic       dack, rd_stb, wr_stb, adv, done;

  typedef struct {
    logic [4:0] exp;
    string      req;
  } item_t;

  item_t sb_q[$];
  int total = 0;
  int bad   = 0;

  dma_xfer_seq dut (
    .clk(clk), .rst_n(rst_n), .grant(grant), .dreq(dreq),
    .xfer_mode(xfer_mode), .mem2mem(mem2mem), .compressed(compressed),
    .ext_write(ext_write), .tc(tc), .eop_n(eop_n),
    .dack(dack), .rd_stb(rd_stb), .wr_stb(wr_stb), .adv(adv), .done(done)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // expected {dack,rd,wr,adv,done} per transfer phase
  function automatic logic [4:0] ev(int ph, bit ext, bit ce, bit dn);
    case (ph)
      1:       return 5'b10000;
      2:       return {1'b1, 1'b1, (ce | ext), 1'b0, 1'b0};
      3:       return 5'b11100;
      4:       return {4'b1001, dn};
      11:      return 5'b10000;
      12, 13:  return 5'b11000;
      14:      return 5'b10010;
      21:      return 5'b10000;
      22:      return {2'b10, ext, 2'b00};
      23:      return 5'b10100;
      24:      return {4'b1001, dn};
      default: return 5'b00000;
    endcase
  endfunction

  task automatic push(input logic [4:0] e, input string r);
    item_t it;
    it.exp = e;
    it.req = r;
    sb_q.push_back(it);
  endtask

  task automatic idle_cycle(input string r);
    @(posedge clk); #1;
    grant = 0; dreq = 0; tc = 0; eop_n = 1;
    push(5'b00000, r);
  endtask

  task automatic run_burst(input string tag, input logic [1:0] md, input bit m2m,
                           input bit cmp, input bit ext, input int ntr, input bit tc_on,
                           input int eop_t, input int dlow_t, input bit s0_abort);
    bit eop_seen = 0;
    bit stop = 0;
    bit ce = cmp & ~m2m;
    int t = 0;
    int ph[8];
    int np;
    // idle cycle carrying the request
    @(posedge clk); #1;
    grant = 1; dreq = 1; xfer_mode = md; mem2mem = m2m; compressed = cmp;
    ext_write = ext; tc = 0; eop_n = 1;
    push(5'b00000, tag);
    // start state
    @(posedge clk); #1;
    dreq = s0_abort ? 1'b0 : 1'b1;
    push(5'b00000, tag);
    if (s0_abort) begin
      idle_cycle(tag);
      idle_cycle(tag);
      return;
    end
    while (!stop && t < 16) begin
      if (m2m) begin
        np = 8;
        ph[0] = 11; ph[1] = 12; ph[2] = 13; ph[3] = 14;
        ph[4] = 21; ph[5] = 22; ph[6] = 23; ph[7] = 24;
      end else if (ce) begin
        if (t == 0) begin np = 3; ph[0] = 1; ph[1] = 2; ph[2] = 4; end
        else        begin np = 2; ph[0] = 2; ph[1] = 4; end
      end else begin
        np = 4; ph[0] = 1; ph[1] = 2; ph[2] = 3; ph[3] = 4;
      end
      for (int p = 0; p < np; p++) begin
        bit dn;
        @(posedge clk); #1;
        tc    = (tc_on && t == ntr - 1);
        eop_n = !(eop_t == t && p == 0);
        dreq  = (dlow_t >= 0 && t >= dlow_t) ? 1'b0 : 1'b1;
        if (!eop_n) eop_seen = 1;
        dn = 0;
        if (p == np - 1) begin
          dn = tc | eop_seen;
          if (!m2m && (md == 2'b01 || md == 2'b11)) dn = 1;
          if (!m2m && md == 2'b00 && !dreq) dn = 1;
          stop = dn;
        end
        push(ev(ph[p], ext, ce, dn), tag);
      end
      t++;
    end
    idle_cycle(tag);
    idle_cycle(tag);
  endtask

  // monitor: compare mid-cycle against scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (sb_q.size() != 0) begin
        item_t it;
        logic [4:0] act;
        it  = sb_q.pop_front();
        act = {dack, rd_stb, wr_stb, adv, done};
        total++;
        if (act !== it.exp) begin
          bad++;
          $display("FAIL %s: got %b expected %b at %0t", it.req, act, it.exp, $time);
        end
      end
    end
  end

  initial begin
    #2_000_000;
    bad++;
    $display("FAIL watchdog: run did not finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 0; grant = 0; dreq = 0; xfer_mode = 2'b00; mem2mem = 0;
    compressed = 0; ext_write = 0; tc = 0; eop_n = 1;
    // R1: outputs low during reset, request without grant ignored
    for (int i = 0; i < 3; i++) begin
      @(posedge clk); #1;
      dreq = 1;
      push(5'b00000, "R1");
    end
    rst_n = 1;
    for (int i = 0; i < 6; i++) begin
      @(posedge clk); #1;
      dreq = 1; grant = 0;
      push(5'b00000, "R1");
    end
    // R3: demand, normal timing, three transfers ended by tc (R11)
    run_burst("R3", 2'b00, 0, 0, 0, 3, 1, -1, -1, 0);
    // R4 + R8: single mode with extended write
    run_burst("R4", 2'b01, 0, 0, 1, 5, 0, -1, -1, 0);
    // R8: single mode, late write
    run_burst("R8", 2'b01, 0, 0, 0, 5, 0, -1, -1, 0);
    // R5: compressed with ext_write set, three transfers
    run_burst("R5", 2'b00, 0, 1, 1, 3, 1, -1, -1, 0);
    // R5: compressed block, two transfers
    run_burst("R5", 2'b10, 0, 1, 0, 2, 1, -1, -1, 0);
    // R6: mem2mem, compressed ignored, dreq dropped mid-burst, tc on 3rd
    run_burst("R6", 2'b00, 1, 1, 0, 3, 1, -1, 1, 0);
    // R6: mem2mem with extended write, single mode setting ignored
    run_burst("R6", 2'b01, 1, 0, 1, 2, 1, -1, -1, 0);
    // R7: demand ends after transfer where dreq falls
    run_burst("R7", 2'b00, 0, 0, 0, 6, 0, -1, 1, 0);
    // R9: block ignores dreq low, ends on tc
    run_burst("R9", 2'b10, 0, 0, 0, 3, 1, -1, 0, 0);
    // R10: end-of-process in block mode ends after second transfer
    run_burst("R10", 2'b10, 0, 0, 0, 6, 0, 1, -1, 0);
    // R10: end-of-process in mem2mem read half
    run_burst("R10", 2'b10, 1, 0, 0, 6, 0, 0, -1, 0);
    // R2: dreq dropped in the start state, no transfer
    run_burst("R2", 2'b10, 0, 0, 0, 3, 1, -1, -1, 1);
    // R11: tc on first of a demand burst
    run_burst("R11", 2'b00, 0, 0, 0, 1, 1, -1, -1, 0);
    repeat (4) @(posedge clk);
    if (sb_q.size() != 0) begin
      bad++;
      $display("FAIL scoreboard: got %0d pending expected 0", sb_q.size());
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule